// File: doc/BRIEF.md
# Segmentable Event Delay Chain

This block turns elapsed time into position. It holds a row of delay cells. A token placed in a cell stays there for a fixed number of sub-stage steps and then leaves. When a token leaves a cell, that cell raises an output event that carries its index. The token then moves into the next cell if the boundary between the two cells is joined. If the boundary is broken, the token is dropped. An incoming address event places a token directly into any cell, so a single physical chain can act as several independent delay lines that start wherever the user chooses.

Every cell's step length is the same, and software sets it as a count of clock cycles. Output events from all cells are collected as pending flags. They leave the block one at a time on a request/acknowledge port, and the lowest cell index goes first. A user taps the chain at chosen cells to learn how long ago a token entered upstream.

Top module: `event_delay_chain`

## Requirements
- R1: After reset, `ev_req_o` is low and no cell holds a token.
- R2: A token injected into cell k produces exactly one event with `ev_addr_o` = k. With `unit_cycles_i` = 0, `ev_req_o` is first seen high SUB_STAGES+1 clock edges after the injection edge.
- R3: When `link_i[k]` = 1, a token leaving cell k enters cell k+1 on the same edge. Cell k+1 then reports its own event SUB_STAGES step periods later.
- R4: When `link_i[k]` = 0, a token leaving cell k is dropped, and cell k+1 reports no event for it.
- R5: A token leaving the highest cell is dropped. It never wraps to cell 0.
- R6: One step lasts `unit_cycles_i`+1 clock cycles, so events from consecutive joined cells are exactly SUB_STAGES*(`unit_cycles_i`+1) cycles apart.
- R7: A token that arrives at a cell already holding one merges with it. Only one event results, at the time of the earlier token, and the total number of tokens never grows except through injection.
- R8: When several events are pending, they are delivered lowest index first, whatever order they were raised in.
- R9: While `ev_req_o` is high and `ev_ack_i` is low, `ev_req_o` and `ev_addr_o` hold their values.
- R10: An injection whose address is N_CELLS or above has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| unit_cycles_i | input | UNIT_W | Step length minus one, in clock cycles |
| link_i | input | N_CELLS-1 | Bit k = 1 joins cell k to cell k+1 |
| inj_valid_i | input | 1 | Inject a token this cycle |
| inj_addr_i | input | IDX_W | Cell that receives the injected token |
| ev_req_o | output | 1 | Output event request |
| ev_addr_o | output | IDX_W | Index of the cell that emitted the event |
| ev_ack_i | input | 1 | Event accepted when high together with `ev_req_o` |

## Verification
The bench checks exact event latency from the injection edge. A cell that counts one step too many or too few would shift every event by one step period. A second injection into a busy cell must not restart that cell's count; a design that re-queues or restarts it would give a late or duplicated event. The bench breaks the chain at chosen boundaries and also checks the end of the chain, to catch tokens that leak across a break or wrap around. It holds back the acknowledge while events queue up in high-to-low order, which exposes a first-come arbiter and an address that changes while a request is still waiting.

// File: rtl/evdl_pkg.sv
package evdl_pkg;
  // Width that can hold an index in 0..n-1 (at least one bit)
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/evdl_tick.sv
// Step-period prescaler: one tick every period_i+1 cycles
module evdl_tick #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q >= period_i);
    cnt_d  = tick_o ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evdl_cell.sv
// One delay cell: holds a token for SUB step ticks
module evdl_cell #(
  parameter int unsigned SUB   = 16,
  parameter int unsigned STG_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic take_i,
  output logic busy_o,
  output logic done_o
);
  logic             busy_q, busy_d;
  logic [STG_W-1:0] stg_q, stg_d;
  logic             en;

  assign busy_o = busy_q;
  assign done_o = busy_q & tick_i & (stg_q == STG_W'(SUB - 1));

  always_comb begin
    busy_d = busy_q;
    stg_d  = stg_q;
    if (take_i && (!busy_q || done_o)) begin
      busy_d = 1'b1;           // fresh token (cell empty or emptying now)
      stg_d  = '0;
    end else if (done_o) begin
      busy_d = 1'b0;
      stg_d  = '0;
    end else if (busy_q && tick_i) begin
      stg_d  = stg_q + STG_W'(1); // arrivals into a busy cell merge
    end
    en = take_i | (busy_q & tick_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      stg_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      stg_q  <= stg_d;
    end
  end
endmodule

// File: rtl/evdl_arb.sv
// Pending event flags, lowest-index-first selection, held output request
module evdl_arb #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     done_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [IDX_W-1:0] addr_o,
  output logic [N-1:0]     pend_o
);
  logic [N-1:0]     pend_q, pend_d, clr;
  logic [IDX_W-1:0] low_idx, addr_q, addr_d;
  logic             vld_q, vld_d, any, load;

  always_comb begin
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) low_idx = IDX_W'(i);
    end
    any  = |pend_q;
    load = !vld_q || ack_i;
    clr  = '0;
    if (load && any) clr[low_idx] = 1'b1;
    pend_d = (pend_q & ~clr) | done_i;
    vld_d  = any;
    addr_d = any ? low_idx : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (load) begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
    end
  end

  assign req_o  = vld_q;
  assign addr_o = addr_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/event_delay_chain.sv
module event_delay_chain #(
  parameter int unsigned N_CELLS    = 880,
  parameter int unsigned SUB_STAGES = 16,
  parameter int unsigned UNIT_W     = 8,
  localparam int unsigned IDX_W     = evdl_pkg::idx_bits(N_CELLS),
  localparam int unsigned STG_W     = evdl_pkg::idx_bits(SUB_STAGES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [UNIT_W-1:0]  unit_cycles_i,
  input  logic [N_CELLS-2:0] link_i,
  input  logic               inj_valid_i,
  input  logic [IDX_W-1:0]   inj_addr_i,
  output logic               ev_req_o,
  output logic [IDX_W-1:0]   ev_addr_o,
  input  logic               ev_ack_i
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               tick;
  logic [N_CELLS-1:0] take_vec, busy_vec, done_vec, pend_vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  evdl_tick #(.W(UNIT_W)) i_tick (
    .clk(clk), .rst_n(rst_int_n), .period_i(unit_cycles_i), .tick_o(tick)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic hit;
    assign hit = inj_valid_i && (inj_addr_i == IDX_W'(k));
    if (k == 0) begin : g_head
      assign take_vec[k] = hit;
    end else begin : g_body
      assign take_vec[k] = hit | (link_i[k-1] & done_vec[k-1]);
    end
    evdl_cell #(.SUB(SUB_STAGES), .STG_W(STG_W)) i_cell (
      .clk(clk), .rst_n(rst_int_n), .tick_i(tick), .take_i(take_vec[k]),
      .busy_o(busy_vec[k]), .done_o(done_vec[k])
    );
  end

  evdl_arb #(.N(N_CELLS), .IDX_W(IDX_W)) i_arb (
    .clk(clk), .rst_n(rst_int_n), .done_i(done_vec), .ack_i(ev_ack_i),
    .req_o(ev_req_o), .addr_o(ev_addr_o), .pend_o(pend_vec)
  );
endmodule

// File: rtl/event_delay_chain_chk.sv
module event_delay_chain_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_req_o,
  input logic [IDX_W-1:0] ev_addr_o,
  input logic             ev_ack_i,
  input logic             inj_valid_i,
  input logic [N-1:0]     busy_vec,
  input logic [N-1:0]     pend_vec
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req_o && !ev_ack_i |=> ev_req_o && $stable(ev_addr_o));

  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req_o |-> ({1'b0, ev_addr_o} < (IDX_W + 1)'(N)));

  // R8
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_req_o) |-> $past(|pend_vec));

  // R7
  no_token_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_valid_i |=> $countones(busy_vec) <= $past($countones(busy_vec)));
endmodule

bind event_delay_chain event_delay_chain_chk #(.N(N_CELLS), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ev_req_o(ev_req_o), .ev_addr_o(ev_addr_o),
  .ev_ack_i(ev_ack_i), .inj_valid_i(inj_valid_i),
  .busy_vec(busy_vec), .pend_vec(pend_vec)
);

// File: tb/test_event_delay_chain.sv
module test_event_delay_chain;
  localparam int CLK_P = 10;
  localparam int N     = 6;
  localparam int SUB   = 4;
  localparam int UW    = 4;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [UW-1:0] unit_cycles;
  logic [N-2:0]  link;
  logic          inj_valid;
  logic [IW-1:0] inj_addr;
  logic          ev_req;
  logic [IW-1:0] ev_addr;
  logic          ev_ack;

  int n_run = 0, n_fail = 0, cyc = 0, t0 = 0, n_ev = 0;
  int ev_a[16];
  int ev_c[16];
  bit done_flag = 1'b0;

  always #(CLK_P / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  event_delay_chain #(.N_CELLS(N), .SUB_STAGES(SUB), .UNIT_W(UW)) i_event_delay_chain (
    .clk(clk), .rst_n(rst_n), .unit_cycles_i(unit_cycles), .link_i(link),
    .inj_valid_i(inj_valid), .inj_addr_i(inj_addr),
    .ev_req_o(ev_req), .ev_addr_o(ev_addr), .ev_ack_i(ev_ack)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset(input int u, input logic [N-2:0] lk);
    @(negedge clk);
    rst_n = 1'b0; unit_cycles = UW'(u); link = lk;
    inj_valid = 1'b0; inj_addr = '0; ev_ack = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_ev = 0;
  endtask

  task automatic inject(input int a);
    @(negedge clk);
    inj_valid = 1'b1; inj_addr = IW'(a);
    @(negedge clk);
    t0 = cyc; inj_valid = 1'b0;
  endtask

  task automatic capture(input int m);
    for (int i = 0; i < m; i++) begin
      @(posedge clk); @(negedge clk);
      if (ev_req) begin
        if (n_ev < 16) begin ev_a[n_ev] = int'(ev_addr); ev_c[n_ev] = cyc - t0; end
        n_ev++;
      end
    end
  endtask

  task automatic t_reset();
    do_reset(0, '0);
    chk(ev_req == 1'b0, "R1 req after reset", int'(ev_req), 0);
    capture(10);
    chk(n_ev == 0, "R1 no event while idle", n_ev, 0);
  endtask

  task automatic t_single();
    do_reset(0, '0);
    inject(2);
    capture(40);
    chk(n_ev == 1, "R4 single event with broken links", n_ev, 1);
    chk(ev_a[0] == 2, "R2 event address", ev_a[0], 2);
    chk(ev_c[0] == SUB + 1, "R2 event latency", ev_c[0], SUB + 1);
  endtask

  task automatic t_chain_end();
    do_reset(0, '1);
    inject(3);
    capture(50);
    chk(n_ev == 3, "R5 no wrap past last cell", n_ev, 3);
    for (int i = 0; i < 3; i++) begin
      chk(ev_a[i] == 3 + i, "R3 chained address", ev_a[i], 3 + i);
      chk(ev_c[i] == SUB * (i + 1) + 1, "R3 chained timing", ev_c[i], SUB * (i + 1) + 1);
    end
  endtask

  task automatic t_break();
    logic [N-2:0] lk;
    lk = '1; lk[2] = 1'b0;
    do_reset(0, lk);
    inject(0);
    capture(50);
    chk(n_ev == 3, "R4 token stops at broken boundary", n_ev, 3);
    chk(ev_a[2] == 2, "R4 last event before break", ev_a[2], 2);
  endtask

  task automatic t_unit();
    do_reset(2, '1);
    inject(0);
    capture(120);
    chk(n_ev == 6, "R6 events along full chain", n_ev, 6);
    for (int i = 1; i < 6; i++)
      chk(ev_c[i] - ev_c[i-1] == SUB * 3, "R6 spacing per cell", ev_c[i] - ev_c[i-1], SUB * 3);
  endtask

  task automatic t_merge();
    do_reset(0, '0);
    inject(4);
    @(posedge clk); @(negedge clk);
    inj_valid = 1'b1; inj_addr = IW'(4);
    @(posedge clk); @(negedge clk);
    inj_valid = 1'b0;
    capture(40);
    chk(n_ev == 1, "R7 merged token gives one event", n_ev, 1);
    chk(ev_c[0] == SUB + 1, "R7 merged event keeps first timing", ev_c[0], SUB + 1);
  endtask

  task automatic t_priority();
    int got[3];
    do_reset(0, '0);
    ev_ack = 1'b0;
    inject(5); inject(2); inject(1);
    repeat (10) @(negedge clk);
    chk(ev_req && ev_addr == 5, "R9 request waits with first event", int'(ev_addr), 5);
    repeat (3) @(negedge clk);
    chk(ev_req && ev_addr == 5, "R9 request held without ack", int'(ev_addr), 5);
    ev_ack = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      got[i] = ev_req ? int'(ev_addr) : -1;
    end
    chk(got[0] == 1, "R8 lowest index first", got[0], 1);
    chk(got[1] == 2, "R8 next index", got[1], 2);
    chk(got[2] == -1, "R8 queue drained", got[2], -1);
  endtask

  task automatic t_range();
    do_reset(0, '1);
    inject(7);
    capture(40);
    chk(n_ev == 0, "R10 out-of-range injection ignored", n_ev, 0);
  endtask

  initial begin
    rst_n = 1'b0; unit_cycles = '0; link = '0;
    inj_valid = 1'b0; inj_addr = '0; ev_ack = 1'b1;
    t_reset();
    t_single();
    t_chain_end();
    t_break();
    t_unit();
    t_merge();
    t_priority();
    t_range();
    summary();
  end

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end
endmodule